// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block keeps the 12-bit instruction fetch address of a small 8-bit controller core and works out the next one every instruction cycle. The decoder presents an operation code for the instruction now executing, along with that instruction's 10-bit immediate, the accumulator value, the two page-select bits from the status register, and the status byte. From these the block steps, jumps, calls, returns, or applies the accumulator as a computed target or offset. Each kind of PC write handles address bits 8 and 9 in its own way: it clears them, keeps them, or loads them. Bits 10 and 11 come from the page-select bits on jump, call, PC load and PC add. A table lookup leaves them as they are.

An eight-entry circular return stack holds the return addresses for calls and interrupts. An interrupt request preempts the current instruction. The block then pushes the address of that instruction, which has not run, and vectors to 0x008. It also saves the accumulator, status and page-select values into shadow registers. Return-from-interrupt gives those values back on the restore outputs, with a one-cycle load strobe, and pops the return address.

All outputs are registered. An operation applied in one cycle shows up on the outputs right after the next rising clock edge.

Top module: `pc_stack_unit`

## Requirements
- R1: A synchronous active-high reset drives the fetch address to 0x000, sets the restore outputs and the load strobe to zero, clears the overflow flag, empties the stack and clears the shadow registers.
- R2: Op code 0 (step) sets the next fetch address to the current address plus one, modulo 4096, so 0xFFF is followed by 0x000.
- R3: Op code 1 (jump) loads the next address as {page[1], page[0], imm[9:0]}.
- R4: Op code 2 (call) loads the address the same way as a jump and pushes the current address plus one. Op code 3 (return) and op code 4 (return with literal) pop the top of the stack into the fetch address.
- R5: Op code 6 (accumulator to PC) loads {page[1:0], 2'b00, acc[7:0]}.
- R6: Op code 7 (add accumulator to PC) loads {page[1:0], 2'b00, (pc[7:0] + acc) mod 256}, where pc is the current fetch address.
- R7: Op code 8 (table lookup) loads {pc[11:8], (pc[7:0] + acc) mod 256}. Bits 8 to 11 do not change, and the carry out of the low byte is dropped.
- R8: When the interrupt request is high and no interrupt is in service, the block ignores the op code. The next address is 0x008, the current address is pushed, and the accumulator, status and page-select inputs are saved.
- R9: While an interrupt is in service, the interrupt request has no effect. Op code 5 (return from interrupt) pops the return address, pulses the load strobe for one cycle, presents the saved accumulator, status and page values on the restore outputs, and ends the service so a new request is accepted.
- R10: The stack is last-in first-out with 8 entries. A push onto a full stack overwrites the oldest entry and sets the overflow flag, which then stays set until reset.
- R11: A pop from an empty stack returns the most recently pushed or popped address (0x000 after reset) and leaves the stack empty.
- R12: Op codes 9 to 15 behave as a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Decoded PC operation of the executing instruction |
| imm_i | input | 10 | Immediate address field for jump and call |
| acc_i | input | 8 | Accumulator value |
| status_i | input | 8 | Status register value, saved on interrupt |
| page_i | input | 2 | Page-select bits, bit 0 feeds address bit 10 |
| irq_i | input | 1 | Interrupt request |
| fetch_addr_o | output | 12 | Current fetch address |
| ctx_load_o | output | 1 | One-cycle strobe after a return from interrupt |
| rest_acc_o | output | 8 | Restored accumulator value |
| rest_status_o | output | 8 | Restored status value |
| rest_page_o | output | 2 | Restored page-select value |
| stk_ovf_o | output | 1 | Sticky return-stack overflow flag |

## Verification
The hardest situations to reach from the ports are the stack edges: a ninth push that wraps over the oldest entry, followed by a run of pops that ends with a pop from an empty stack. The bench reaches them with nine calls in a row and then nine returns. It expects the overflow flag after the ninth call, the return addresses in reverse order down to the second call, and the second call's return address again on the empty pop. Interrupt masking is reached by holding the request high across the vector and into the service routine, before the return from interrupt.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
package pcu_pkg;
  localparam int LOW_W  = 10;
  localparam int PAGE_W = 2;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = LOW_W + PAGE_W;
  localparam int OP_W   = 4;

  localparam logic [OP_W-1:0] OP_SEQ  = 4'd0;
  localparam logic [OP_W-1:0] OP_JMP  = 4'd1;
  localparam logic [OP_W-1:0] OP_CALL = 4'd2;
  localparam logic [OP_W-1:0] OP_RET  = 4'd3;
  localparam logic [OP_W-1:0] OP_RETL = 4'd4;
  localparam logic [OP_W-1:0] OP_RETI = 4'd5;
  localparam logic [OP_W-1:0] OP_MOVP = 4'd6;
  localparam logic [OP_W-1:0] OP_ADDP = 4'd7;
  localparam logic [OP_W-1:0] OP_TBL  = 4'd8;
endpackage

// File: rtl/pcu_next_addr.sv
`timescale 1ns/1ps
module pcu_next_addr
  import pcu_pkg::*;
#(
  parameter int LOW_W  = pcu_pkg::LOW_W,
  parameter int PAGE_W = pcu_pkg::PAGE_W,
  parameter int BYTE_W = pcu_pkg::BYTE_W,
  parameter int ADDR_W = LOW_W + PAGE_W,
  parameter logic [ADDR_W-1:0] VEC = 'h008
) (
  input  logic [OP_W-1:0]   op,
  input  logic [ADDR_W-1:0] pc,
  input  logic [LOW_W-1:0]  imm,
  input  logic [BYTE_W-1:0] acc,
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] pop_data,
  input  logic              irq_take,
  output logic [ADDR_W-1:0] nxt,
  output logic [ADDR_W-1:0] push_data,
  output logic              push,
  output logic              pop,
  output logic              reti
);
  localparam int MID_W = LOW_W - BYTE_W;
  localparam logic [ADDR_W-1:0] ONE = 1;

  logic [ADDR_W-1:0] seq;
  logic [BYTE_W-1:0] lo_sum;

  always_comb begin
    seq       = pc + ONE;
    lo_sum    = pc[BYTE_W-1:0] + acc;
    nxt       = seq;
    push_data = seq;
    push      = 1'b0;
    pop       = 1'b0;
    reti      = 1'b0;
    if (irq_take) begin
      // the interrupted instruction has not run, so it is the return target
      nxt       = VEC;
      push      = 1'b1;
      push_data = pc;
    end else begin
      case (op)
        OP_JMP:  nxt = {page, imm};
        OP_CALL: begin
          nxt  = {page, imm};
          push = 1'b1;
        end
        OP_RET, OP_RETL: begin
          nxt = pop_data;
          pop = 1'b1;
        end
        OP_RETI: begin
          nxt  = pop_data;
          pop  = 1'b1;
          reti = 1'b1;
        end
        OP_MOVP: nxt = {page, {MID_W{1'b0}}, acc};
        OP_ADDP: nxt = {page, {MID_W{1'b0}}, lo_sum};
        OP_TBL:  nxt = {pc[ADDR_W-1:BYTE_W], lo_sum};
        default: nxt = seq;
      endcase
    end
  end
endmodule

// File: rtl/pcu_ret_stack.sv
`timescale 1ns/1ps
module pcu_ret_stack #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] rdata,
  output logic              ovf
);
  // DEPTH is a power of two so the pointer wraps by itself
  localparam int SP_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [SP_W-1:0]  SP_ONE = 1;
  localparam logic [CNT_W-1:0] C_ONE  = 1;
  localparam logic [CNT_W-1:0] C_FULL = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [SP_W-1:0]   wp;
  logic [SP_W-1:0]   top_ptr;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] last_q;
  logic              empty;

  assign top_ptr = wp - SP_ONE;
  assign empty   = (cnt == '0);
  assign rdata   = empty ? last_q : mem[top_ptr];

  // storage without reset, written from one port only
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      cnt    <= '0;
      last_q <= '0;
      ovf    <= 1'b0;
    end else if (push) begin
      wp     <= wp + SP_ONE;
      last_q <= wdata;
      if (cnt == C_FULL) ovf <= 1'b1;
      else               cnt <= cnt + C_ONE;
    end else if (pop && !empty) begin
      wp     <= top_ptr;
      cnt    <= cnt - C_ONE;
      last_q <= rdata;
    end
  end

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cnt <= C_FULL);
  p_ovf_set_r10: assert property (@(posedge clk) disable iff (rst)
    (push && cnt == C_FULL) |=> ovf);
  p_ovf_hold_r10: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  p_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> (empty && rdata == $past(rdata)));
endmodule

// File: rtl/pcu_ctx_shadow.sv
`timescale 1ns/1ps
module pcu_ctx_shadow #(
  parameter int BYTE_W = 8,
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              save,
  input  logic              restore,
  input  logic [BYTE_W-1:0] acc_in,
  input  logic [BYTE_W-1:0] st_in,
  input  logic [PAGE_W-1:0] pg_in,
  output logic              load_o,
  output logic [BYTE_W-1:0] acc_o,
  output logic [BYTE_W-1:0] st_o,
  output logic [PAGE_W-1:0] pg_o
);
  logic [BYTE_W-1:0] sh_acc, sh_st;
  logic [PAGE_W-1:0] sh_pg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_acc <= '0;
      sh_st  <= '0;
      sh_pg  <= '0;
      acc_o  <= '0;
      st_o   <= '0;
      pg_o   <= '0;
      load_o <= 1'b0;
    end else begin
      load_o <= restore;
      if (save) begin
        sh_acc <= acc_in;
        sh_st  <= st_in;
        sh_pg  <= pg_in;
      end
      if (restore) begin
        acc_o <= sh_acc;
        st_o  <= sh_st;
        pg_o  <= sh_pg;
      end
    end
  end

  p_restore_r9: assert property (@(posedge clk) disable iff (rst)
    (restore && !save) |=> (load_o && acc_o == $past(sh_acc)));
endmodule

// File: rtl/pc_stack_unit.sv
`timescale 1ns/1ps
module pc_stack_unit
  import pcu_pkg::*;
#(
  parameter int LOW_W     = pcu_pkg::LOW_W,
  parameter int PAGE_W    = pcu_pkg::PAGE_W,
  parameter int BYTE_W    = pcu_pkg::BYTE_W,
  parameter int STK_DEPTH = 8,
  parameter int ADDR_W    = LOW_W + PAGE_W,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 'h008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [LOW_W-1:0]  imm_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              irq_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              ctx_load_o,
  output logic [BYTE_W-1:0] rest_acc_o,
  output logic [BYTE_W-1:0] rest_status_o,
  output logic [PAGE_W-1:0] rest_page_o,
  output logic              stk_ovf_o
);
  localparam logic [ADDR_W-1:0] ONE = 1;

  logic              in_isr;
  logic              irq_take;
  logic [ADDR_W-1:0] nxt, push_data, pop_data;
  logic              push, pop, reti;

  assign irq_take = irq_i && !in_isr;

  pcu_next_addr #(
    .LOW_W(LOW_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .VEC(IRQ_VEC)
  ) u_next (
    .op(op_i), .pc(fetch_addr_o), .imm(imm_i), .acc(acc_i), .page(page_i),
    .pop_data(pop_data), .irq_take(irq_take), .nxt(nxt), .push_data(push_data),
    .push(push), .pop(pop), .reti(reti)
  );

  pcu_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .wdata(push_data),
    .rdata(pop_data), .ovf(stk_ovf_o)
  );

  pcu_ctx_shadow #(.BYTE_W(BYTE_W), .PAGE_W(PAGE_W)) u_shadow (
    .clk(clk), .rst(rst), .save(irq_take), .restore(reti),
    .acc_in(acc_i), .st_in(status_i), .pg_in(page_i),
    .load_o(ctx_load_o), .acc_o(rest_acc_o), .st_o(rest_status_o), .pg_o(rest_page_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_addr_o <= '0;
      in_isr       <= 1'b0;
    end else begin
      fetch_addr_o <= nxt;
      if (irq_take)  in_isr <= 1'b1;
      else if (reti) in_isr <= 1'b0;
    end
  end

  p_seq_r2: assert property (@(posedge clk) disable iff (rst)
    (!irq_take && op_i == OP_SEQ) |=> fetch_addr_o == $past(fetch_addr_o) + ONE);
  p_jmp_r3: assert property (@(posedge clk) disable iff (rst)
    (!irq_take && op_i == OP_JMP) |=> fetch_addr_o == {$past(page_i), $past(imm_i)});
  p_tbl_r7: assert property (@(posedge clk) disable iff (rst)
    (!irq_take && op_i == OP_TBL)
      |=> fetch_addr_o[ADDR_W-1:BYTE_W] == $past(fetch_addr_o[ADDR_W-1:BYTE_W]));
  p_vec_r8: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> fetch_addr_o == IRQ_VEC);
  p_reti_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (!irq_take && op_i == OP_RETI) |=> ctx_load_o);
endmodule

// File: tb/sim_pc_stack_unit.sv
`timescale 1ns/1ps
module sim_pc_stack_unit;
  import pcu_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic [3:0]  op;
  logic [9:0]  imm;
  logic [7:0]  acc, st;
  logic [1:0]  pg;
  logic        irq;
  logic [11:0] fetch;
  logic        ld;
  logic [7:0]  ra, rs;
  logic [1:0]  rp;
  logic        ovf;

  pc_stack_unit u0 (
    .clk(clk), .rst(rst), .op_i(op), .imm_i(imm), .acc_i(acc), .status_i(st),
    .page_i(pg), .irq_i(irq), .fetch_addr_o(fetch), .ctx_load_o(ld),
    .rest_acc_o(ra), .rest_status_o(rs), .rest_page_o(rp), .stk_ovf_o(ovf)
  );

  typedef struct {
    logic [11:0] addr;
    logic        ld;
    logic [7:0]  ra, rs;
    logic [1:0]  rp;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  // reference state, built from the requirements
  logic [11:0] m_pc, m_last;
  logic [11:0] m_stk [8];
  int          m_wp, m_cnt;
  logic        m_isr, m_ovf;
  logic [7:0]  s_acc, s_st, m_ra, m_rs;
  logic [1:0]  s_pg, m_rp;

  task automatic m_push(input logic [11:0] v);
    m_stk[m_wp] = v;
    m_wp = (m_wp + 1) % 8;
    m_last = v;
    if (m_cnt == 8) m_ovf = 1'b1;
    else m_cnt++;
  endtask

  task automatic m_pop(output logic [11:0] v);
    if (m_cnt == 0) v = m_last;
    else begin
      m_wp = (m_wp + 7) % 8;
      v = m_stk[m_wp];
      m_cnt--;
      m_last = v;
    end
  endtask

  task automatic do_op(input logic [3:0] o, input logic [9:0] im, input logic [7:0] a,
                       input logic [7:0] s, input logic [1:0] p, input logic ir,
                       input string tag);
    exp_t e;
    logic [11:0] n;
    logic [7:0]  lo;
    logic        l;
    @(negedge clk);
    op = o; imm = im; acc = a; st = s; pg = p; irq = ir;
    l  = 1'b0;
    lo = m_pc[7:0] + a;
    n  = m_pc + 12'd1;
    if (ir && !m_isr) begin
      m_push(m_pc);
      n = 12'h008;
      s_acc = a; s_st = s; s_pg = p;
      m_isr = 1'b1;
    end else begin
      case (o)
        4'd1: n = {p, im};
        4'd2: begin m_push(m_pc + 12'd1); n = {p, im}; end
        4'd3, 4'd4: m_pop(n);
        4'd5: begin
          m_pop(n);
          l = 1'b1; m_ra = s_acc; m_rs = s_st; m_rp = s_pg;
          m_isr = 1'b0;
        end
        4'd6: n = {p, 2'b00, a};
        4'd7: n = {p, 2'b00, lo};
        4'd8: n = {m_pc[11:8], lo};
        default: n = m_pc + 12'd1;
      endcase
    end
    m_pc = n;
    e.addr = n; e.ld = l; e.ra = m_ra; e.rs = m_rs; e.rp = m_rp; e.ovf = m_ovf; e.tag = tag;
    @(posedge clk);
    #1;
    q.push_back(e);
  endtask

  // monitor: compares each expected item half a cycle after the edge that produced it
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (fetch !== e.addr || ld !== e.ld || ra !== e.ra || rs !== e.rs ||
          rp !== e.rp || ovf !== e.ovf) begin
        errors++;
        $display("FAIL %s addr act %h exp %h ld act %b exp %b acc act %h exp %h st act %h exp %h pg act %h exp %h ovf act %b exp %b",
                 e.tag, fetch, e.addr, ld, e.ld, ra, e.ra, rs, e.rs, rp, e.rp, ovf, e.ovf);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, act hung exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; op = 4'd0; imm = '0; acc = '0; st = '0; pg = '0; irq = 1'b0;
    m_pc = '0; m_last = '0; m_wp = 0; m_cnt = 0; m_isr = 0; m_ovf = 0;
    s_acc = '0; s_st = '0; s_pg = '0; m_ra = '0; m_rs = '0; m_rp = '0;
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    checks++;
    if (fetch !== 12'h000 || ld !== 1'b0 || ra !== 8'h00 || rs !== 8'h00 ||
        rp !== 2'b00 || ovf !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset act %h/%b/%h/%h/%h/%b exp 000/0/00/00/0/0",
               fetch, ld, ra, rs, rp, ovf);
    end
    do_op(4'd3, 10'h000, 8'h00, 8'h00, 2'd0, 1'b0, "R11 empty pop after reset R1");
    do_op(4'd0, 10'h000, 8'h00, 8'h00, 2'd0, 1'b0, "R2 step");
    do_op(4'd0, 10'h000, 8'h00, 8'h00, 2'd0, 1'b0, "R2 step");
    do_op(4'd1, 10'h155, 8'h00, 8'h00, 2'd2, 1'b0, "R3 jump");
    do_op(4'd2, 10'h3FF, 8'h00, 8'h00, 2'd1, 1'b0, "R4 call");
    do_op(4'd0, 10'h000, 8'h00, 8'h00, 2'd0, 1'b0, "R2 step in callee");
    do_op(4'd2, 10'h021, 8'h00, 8'h00, 2'd3, 1'b0, "R4 nested call");
    do_op(4'd4, 10'h000, 8'h00, 8'h00, 2'd0, 1'b0, "R4 return with literal");
    do_op(4'd3, 10'h000, 8'h00, 8'h00, 2'd0, 1'b0, "R4 return");
    do_op(4'd6, 10'h000, 8'hC3, 8'h00, 2'd3, 1'b0, "R5 acc to pc");
    do_op(4'd1, 10'h3F0, 8'h00, 8'h00, 2'd0, 1'b0, "R3 jump page 0");
    do_op(4'd8, 10'h000, 8'h20, 8'h00, 2'd3, 1'b0, "R7 table carry dropped");
    do_op(4'd7, 10'h000, 8'h20, 8'h00, 2'd1, 1'b0, "R6 add to pc");
    do_op(4'd7, 10'h000, 8'hF0, 8'h00, 2'd2, 1'b0, "R6 add wraps byte");
    do_op(4'd12, 10'h3FF, 8'hFF, 8'h00, 2'd3, 1'b0, "R12 unused code");
    do_op(4'd15, 10'h3FF, 8'hFF, 8'h00, 2'd3, 1'b0, "R12 unused code");
    do_op(4'd1, 10'h3FF, 8'h00, 8'h00, 2'd3, 1'b0, "R3 jump to top");
    do_op(4'd0, 10'h000, 8'h00, 8'h00, 2'd0, 1'b0, "R2 wrap to zero");
    do_op(4'd1, 10'h2A4, 8'h00, 8'h00, 2'd1, 1'b0, "R3 jump");
    do_op(4'd1, 10'h111, 8'hA5, 8'h3C, 2'd2, 1'b1, "R8 irq vectors, op ignored");
    do_op(4'd0, 10'h000, 8'h11, 8'h22, 2'd1, 1'b1, "R9 irq masked in service");
    do_op(4'd5, 10'h000, 8'h77, 8'h88, 2'd3, 1'b0, "R9 return from interrupt");
    do_op(4'd0, 10'h000, 8'h00, 8'h00, 2'd0, 1'b0, "R9 strobe ends");
    do_op(4'd2, 10'h0F0, 8'h5A, 8'hC3, 2'd1, 1'b1, "R8 irq accepted again over call");
    do_op(4'd5, 10'h000, 8'h00, 8'h00, 2'd0, 1'b0, "R9 second return restores");
    for (int i = 0; i < 9; i++)
      do_op(4'd2, 10'(i * 40 + 3), 8'h00, 8'h00, 2'(i), 1'b0, "R10 call chain");
    for (int i = 0; i < 8; i++)
      do_op(4'd3, 10'h000, 8'h00, 8'h00, 2'd0, 1'b0, "R10 lifo after overwrite");
    do_op(4'd3, 10'h000, 8'h00, 8'h00, 2'd0, 1'b0, "R11 empty pop repeats last");
    do_op(4'd3, 10'h000, 8'h00, 8'h00, 2'd0, 1'b0, "R11 empty pop again");
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule